// File: doc/BRIEF.md
# Serial-Ordered Trace Stream Merger

The block gathers trace records from several parallel lanes, one lane for each commit slot of a superscalar core, and turns them into a single stream in program order. Each record carries a serial number and an opaque payload. Within a lane, serial numbers always increase. Across all lanes, every serial number appears exactly once. The merger does not arbitrate by priority or in turn. It keeps a register that holds the serial number it needs next. It compares that value with the head record of each valid lane, and it takes a record only from the lane whose head matches.

Every port uses a valid/ready handshake. The chosen record is loaded into a registered output stage, and the expected-serial register then advances by one, wrapping at the width of the serial field. The block moves at most one record per cycle. When the output stage is empty or being drained, it can accept a new record in the same cycle. Two sticky flags report broken input ordering. One covers the case where two lane heads claim the same serial number. The other covers the case where every lane is waiting but none holds the serial number that is needed.

Top module: `trace_merge`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `out_valid`, `err_dup` and `err_stall` after that edge and loads `START_SN` into the expected serial number.
- R2: `in_ready[i]` is high only when lane i is valid, its `in_sn` slice equals the expected serial number, and the output stage can load (`out_valid` low or `out_ready` high). When those conditions hold and no lower-indexed lane also matches, `in_ready[i]` is high.
- R3: The records on the output carry serial numbers that rise by exactly one from `START_SN`, and each record carries the payload of the input record with that serial number, unchanged.
- R4: At most one bit of `in_ready` is high in any cycle. A lane whose head does not match keeps `in_ready` low, so it holds its record.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sn` and `out_data` keep their values on the next cycle.
- R6: The expected serial number wraps from 2^SN_W-1 to 0.
- R7: If two or more valid heads match the expected serial number in the same cycle, `err_dup` goes high after that edge and stays high until reset. The lowest-indexed matching lane is the one forwarded.
- R8: If every lane is valid and none matches, `err_stall` goes high after that edge and stays high until reset. No record is accepted in that cycle.
- R9: A record accepted at a clock edge appears on `out_valid`/`out_sn`/`out_data` right after that edge. The block can accept one record per cycle while `out_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane record valid |
| in_sn | input | LANES*SN_W | Per-lane serial numbers; lane i occupies bits [i*SN_W +: SN_W] |
| in_data | input | LANES*PAY_W | Per-lane payloads; lane i occupies bits [i*PAY_W +: PAY_W] |
| in_ready | output | LANES | Per-lane accept strobe |
| out_valid | output | 1 | Registered output record valid |
| out_sn | output | SN_W | Serial number of the output record |
| out_data | output | PAY_W | Payload of the output record |
| out_ready | input | 1 | Downstream accept |
| err_dup | output | 1 | Sticky flag: two lane heads matched together |
| err_stall | output | 1 | Sticky flag: all lanes valid and none matched |

## Verification
The bench builds the block with three lanes, a 4-bit serial field, 16-bit payloads and a start value of 5. The narrow serial field makes the expected counter wrap many times during a run of about 400 records, and the non-zero start checks the reset load. Using three lanes means a lane can sit idle with a mismatching head while the matching record lives in another lane. It also allows the all-lanes-blocked fault to be built directly. Random lane valids and random back-pressure exercise the hold and the one-per-cycle paths. Directed cases then force a duplicate match and a deadlock, so that both sticky flags and the lowest-index forwarding rule are observed.

// File: rtl/tm_pkg.sv
package tm_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tm_lane_cmp.sv
module tm_lane_cmp #(
  parameter int SN_W = 8
) (
  input  logic            lane_valid,
  input  logic [SN_W-1:0] lane_sn,
  input  logic [SN_W-1:0] want_sn,
  output logic            hit
);
  always_comb hit = lane_valid && (lane_sn == want_sn);
endmodule

// File: rtl/tm_select.sv
module tm_select #(
  parameter int LANES = 2,
  parameter int SEL_W = 1
) (
  input  logic [LANES-1:0] hit,
  output logic [LANES-1:0] grant,
  output logic [SEL_W-1:0] sel_idx,
  output logic             any_hit,
  output logic             multi_hit
);
  always_comb begin
    logic found;
    int   cnt;
    found   = 1'b0;
    cnt     = 0;
    grant   = '0;
    sel_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hit[i]) begin
        cnt = cnt + 1;
        if (!found) begin
          found    = 1'b1;
          grant[i] = 1'b1;
          sel_idx  = SEL_W'(i);
        end
      end
    end
    any_hit   = found;
    multi_hit = (cnt > 1);
  end
endmodule

// File: rtl/tm_out_stage.sv
module tm_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         dn_ready,
  output logic         can_load,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_comb can_load = !q_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q       <= din;
    end else if (dn_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_merge.sv
module trace_merge #(
  parameter int LANES    = 2,
  parameter int SN_W     = 8,
  parameter int PAY_W    = 32,
  parameter int START_SN = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*SN_W-1:0]  in_sn,
  input  logic [LANES*PAY_W-1:0] in_data,
  output logic [LANES-1:0]       in_ready,
  output logic                   out_valid,
  output logic [SN_W-1:0]        out_sn,
  output logic [PAY_W-1:0]       out_data,
  input  logic                   out_ready,
  output logic                   err_dup,
  output logic                   err_stall
);
  localparam int SEL_W = tm_pkg::idx_width(LANES);
  localparam int REC_W = SN_W + PAY_W;

  logic [SN_W-1:0]  exp_sn;
  logic [LANES-1:0] hit;
  logic [LANES-1:0] grant;
  logic [SEL_W-1:0] sel_idx;
  logic             any_hit;
  logic             multi_hit;
  logic             can_load;
  logic             accept;
  logic [REC_W-1:0] sel_rec;
  logic [REC_W-1:0] held_rec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tm_lane_cmp #(.SN_W(SN_W)) u_cmp (
      .lane_valid (in_valid[g]),
      .lane_sn    (in_sn[g*SN_W +: SN_W]),
      .want_sn    (exp_sn),
      .hit        (hit[g])
    );
  end

  tm_select #(.LANES(LANES), .SEL_W(SEL_W)) u_sel (
    .hit       (hit),
    .grant     (grant),
    .sel_idx   (sel_idx),
    .any_hit   (any_hit),
    .multi_hit (multi_hit)
  );

  always_comb begin
    accept   = any_hit && can_load;
    in_ready = grant & {LANES{can_load}};
    sel_rec  = {in_sn[sel_idx*SN_W +: SN_W], in_data[sel_idx*PAY_W +: PAY_W]};
  end

  tm_out_stage #(.W(REC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .din      (sel_rec),
    .dn_ready (out_ready),
    .can_load (can_load),
    .q_valid  (out_valid),
    .q        (held_rec)
  );

  always_comb begin
    out_sn   = held_rec[REC_W-1 -: SN_W];
    out_data = held_rec[PAY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_sn    <= SN_W'(START_SN);
      err_dup   <= 1'b0;
      err_stall <= 1'b0;
    end else begin
      if (accept) exp_sn <= exp_sn + 1'b1;
      if (multi_hit) err_dup <= 1'b1;
      if ((&in_valid) && !any_hit) err_stall <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_merge_chk.sv
module trace_merge_chk #(
  parameter int LANES    = 2,
  parameter int SN_W     = 8,
  parameter int PAY_W    = 32,
  parameter int START_SN = 0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       in_valid,
  input logic [LANES-1:0]       in_ready,
  input logic                   out_valid,
  input logic [SN_W-1:0]        out_sn,
  input logic [PAY_W-1:0]       out_data,
  input logic                   out_ready,
  input logic                   err_dup,
  input logic                   err_stall
);
  logic [SN_W-1:0] last_sn;
  logic            seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_sn <= '0;
    end else if (out_valid && out_ready) begin
      seen    <= 1'b1;
      last_sn <= out_sn;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_dup && !err_stall));

  a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);

  a_r2_ready_needs_room: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> (!out_valid || out_ready));

  a_r4_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sn) && $stable(out_data)));

  a_r3_r6_sequence: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen) |-> (out_sn == SN_W'(last_sn + 1'b1)));

  a_r7_dup_sticky: assert property (@(posedge clk) disable iff (rst)
    err_dup |=> err_dup);

  a_r8_stall_sticky: assert property (@(posedge clk) disable iff (rst)
    err_stall |=> err_stall);
endmodule

bind trace_merge trace_merge_chk #(
  .LANES(LANES), .SN_W(SN_W), .PAY_W(PAY_W), .START_SN(START_SN)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sn(out_sn), .out_data(out_data),
  .out_ready(out_ready), .err_dup(err_dup), .err_stall(err_stall)
);

// File: tb/trace_merge_tb.sv
`timescale 1ns/1ps
module trace_merge_tb;
  localparam int LANES = 3;
  localparam int SN_W  = 4;
  localparam int PAY_W = 16;
  localparam int START = 5;
  localparam int NREC  = 400;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [LANES-1:0]       in_valid;
  logic [LANES*SN_W-1:0]  in_sn;
  logic [LANES*PAY_W-1:0] in_data;
  logic [LANES-1:0]       in_ready;
  logic                   out_valid;
  logic [SN_W-1:0]        out_sn;
  logic [PAY_W-1:0]       out_data;
  logic                   out_ready;
  logic                   err_dup;
  logic                   err_stall;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  trace_merge #(.LANES(LANES), .SN_W(SN_W), .PAY_W(PAY_W), .START_SN(START)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sn(in_sn), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sn(out_sn), .out_data(out_data),
    .out_ready(out_ready), .err_dup(err_dup), .err_stall(err_stall)
  );

  function automatic logic [SN_W-1:0] sn_of(input int abs_idx);
    return SN_W'((START + abs_idx) % (1 << SN_W));
  endfunction

  function automatic logic [PAY_W-1:0] pay_of(input int abs_idx);
    return PAY_W'((abs_idx * 40503 + 23130) ^ (abs_idx << 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = '0; in_sn = '0; in_data = '0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  int lq [LANES][$];

  initial begin
    #700000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int last_use [LANES];
    bit vld [LANES];
    int next_in, next_out, cyc, wraps;
    bit hold_pend;
    logic [SN_W-1:0]  hold_sn;
    logic [PAY_W-1:0] hold_data;
    void'($urandom(32'd1234));

    do_reset();
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(err_dup == 1'b0 && err_stall == 1'b0, "R1 flags", int'({err_dup, err_stall}), 0);

    // Build the lane assignment; every lane gets a record at least every 5 serials
    for (int l = 0; l < LANES; l++) last_use[l] = 0;
    for (int k = 0; k < NREC; k++) begin
      int pick;
      pick = int'($urandom % LANES);
      for (int l = 0; l < LANES; l++) if (k - last_use[l] >= 5) pick = l;
      lq[pick].push_back(k);
      last_use[pick] = k;
    end

    for (int l = 0; l < LANES; l++) vld[l] = 0;
    next_in = 0; next_out = 0; cyc = 0; wraps = 0; hold_pend = 0;
    hold_sn = '0; hold_data = '0;
    while (next_out < NREC && cyc < 20000) begin
      bit acc [LANES];
      int nrdy;
      bit room;
      cyc++;
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      for (int l = 0; l < LANES; l++) begin
        if (!vld[l] && lq[l].size() > 0 && ($urandom % 10) < 6) vld[l] = 1;
        in_valid[l] = vld[l];
        in_sn[l*SN_W +: SN_W]    = vld[l] ? sn_of(lq[l][0]) : '0;
        in_data[l*PAY_W +: PAY_W] = vld[l] ? pay_of(lq[l][0]) : '0;
      end
      #1;
      if (hold_pend) begin
        // R5: held output unchanged
        check(out_valid && out_sn == hold_sn && out_data == hold_data, "R5 hold",
              int'(out_sn), int'(hold_sn));
        hold_pend = 0;
      end
      room = !out_valid || out_ready;
      nrdy = 0;
      for (int l = 0; l < LANES; l++) begin
        acc[l] = in_ready[l];
        if (in_ready[l]) begin
          nrdy++;
          // R2: only the matching lane is granted
          check(vld[l] && lq[l][0] == next_in && room, "R2 grant",
                vld[l] ? lq[l][0] : -1, next_in);
        end else if (vld[l] && lq[l][0] == next_in && room) begin
          check(1'b0, "R2 missing grant", 0, 1);
        end
      end
      // R4: at most one grant
      check(nrdy <= 1, "R4 one grant", nrdy, 1);
      if (out_valid && out_ready) begin
        // R3: order and payload; R6: wrap
        check(out_sn == sn_of(next_out) && out_data == pay_of(next_out), "R3 order/payload",
              int'(out_sn), int'(sn_of(next_out)));
        if (out_sn == '0 && next_out > 0) wraps++;
        next_out++;
      end else if (out_valid) begin
        hold_pend = 1; hold_sn = out_sn; hold_data = out_data;
      end
      @(posedge clk);
      for (int l = 0; l < LANES; l++) if (acc[l]) begin
        void'(lq[l].pop_front());
        vld[l] = 0;
        next_in++;
      end
    end
    check(next_out == NREC, "R3 all records", next_out, NREC);
    check(wraps >= 20, "R6 wraps", wraps, 20);
    check(!err_dup && !err_stall, "R7 R8 no false fault", int'({err_dup, err_stall}), 0);

    // R9: full throughput with out_ready held high
    do_reset();
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      in_valid = '0; in_valid[k % LANES] = 1'b1;
      in_sn[(k % LANES)*SN_W +: SN_W] = sn_of(k);
      in_data[(k % LANES)*PAY_W +: PAY_W] = pay_of(k);
      @(negedge clk);
      check(out_valid && out_sn == sn_of(k), "R9 back-to-back", int'(out_sn), int'(sn_of(k)));
    end

    // R7: duplicate match, lowest lane forwarded, flag sticky
    do_reset();
    out_ready = 1'b1;
    in_valid = 3'b011;
    in_sn[0 +: SN_W] = sn_of(0); in_data[0 +: PAY_W] = 16'hAAAA;
    in_sn[SN_W +: SN_W] = sn_of(0); in_data[PAY_W +: PAY_W] = 16'hBBBB;
    #1;
    check(in_ready == 3'b001, "R7 lowest granted", int'(in_ready), 1);
    @(negedge clk);
    in_valid = '0;
    check(err_dup == 1'b1, "R7 dup flag", int'(err_dup), 1);
    check(out_valid && out_data == 16'hAAAA, "R7 lane0 data", int'(out_data), 16'hAAAA);
    @(negedge clk); @(negedge clk);
    check(err_dup == 1'b1, "R7 sticky", int'(err_dup), 1);

    // R8: all lanes valid, none matching
    do_reset();
    out_ready = 1'b1;
    in_valid = 3'b111;
    for (int l = 0; l < LANES; l++) begin
      in_sn[l*SN_W +: SN_W] = sn_of(2 + l);
      in_data[l*PAY_W +: PAY_W] = pay_of(2 + l);
    end
    #1;
    check(in_ready == '0, "R8 no grant", int'(in_ready), 0);
    @(negedge clk);
    check(err_stall == 1'b1 && !out_valid, "R8 stall flag", int'(err_stall), 1);
    in_valid = '0;
    @(negedge clk); @(negedge clk);
    check(err_stall == 1'b1, "R8 sticky", int'(err_stall), 1);

    // R1: reset clears sticky flags
    do_reset();
    check(!err_stall && !err_dup && !out_valid, "R1 clear after fault",
          int'({err_dup, err_stall}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule